// File: doc/BRIEF.md
# Indexed-Port Real-Time Clock

This block is a calendar clock that software reaches through two byte-wide I/O addresses. A write to the selector address picks one internal register, and a read or write at the value address then reaches that register. Reads have no side effects, and the read data is combinational.

The block holds six time-of-day and date fields. A prescaler counts reference-clock cycles and advances the fields once per second. The fields roll over as a calendar does, with a 24-hour day, month lengths, and leap Februaries. Each field is stored either as packed BCD or as plain binary, chosen by a mode bit in a control register. Changing the mode bit does not convert the stored values. For a fixed number of cycles before each advance, a busy flag is visible in a status register, so software can tell when a read might see a half-updated time.

A spare read/write byte is also provided for software to hold a shutdown code.

Top module: `rtc_port_clock`

## Requirements
- R1: A write to address 0x70 loads the selector. While the address is 0x71, reads return the selected register and writes update it. Selector codes are 0x00 seconds, 0x02 minutes, 0x04 hours, 0x07 day of month, 0x08 month and 0x09 year. Any other address reads as 0x00.
- R2: After reset, the fields read 00:00:00, day 1, month 1, year 0, the control register reads 0x00 (BCD mode), and the spare byte reads 0x00.
- R3: The seconds field advances once every CYC_PER_SEC reference cycles. Bit 7 of the status register (selector 0x0A) reads 1 during the last UIP_CYCLES cycles before each advance and 0 during all other cycles.
- R4: A time field changes only at an advance, which happens while the busy flag is 1, or when software writes that field.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R6: The day wraps to 1 after the last day of the month. February has 29 days when the two-digit year is a multiple of 4, and 28 days otherwise. April, June, September and November have 30 days, and the other months have 31.
- R7: Month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R8: Bit 2 of the control register (selector 0x0B) selects the encoding: 0 means BCD and 1 means binary. Counting uses the selected encoding, and the register reads back as 0x04 or 0x00.
- R9: Changing the encoding bit leaves the stored field bytes unchanged.
- R10: Selector 0x0F is a plain 8-bit read/write byte.
- R11: Unused selector codes read 0x00, and writes to them are ignored. Writes to the status register are ignored, and its bits 6..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for the addressed port |
| io_addr | input | 8 | I/O address (selector or value port) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data from the value port, otherwise 0 |

## Verification
The wrap assertions assume that the fields hold values that are legal in the current encoding. The bench therefore writes only legal BCD or binary values. It loads the fields year first, so no partial date is ever illegal for its month. The bench also relies on software never writing a field in the same cycle as an advance. To keep it that way, every multi-register update starts just after an advance and finishes well before the next busy window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 6;
  // selector codes of the six fields, index 0 = seconds
  localparam logic [NFIELD-1:0][7:0] FIELD_IDX =
    {8'h09, 8'h08, 8'h07, 8'h04, 8'h02, 8'h00};
  localparam logic [7:0] IDX_STA  = 8'h0A;
  localparam logic [7:0] IDX_STB  = 8'h0B;
  localparam logic [7:0] IDX_SHUT = 8'h0F;
  localparam int MODE_BIT = 2;
  localparam int UIP_BIT  = 7;

  // stored byte -> binary value
  function automatic logic [6:0] fld_to_bin(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  // binary value -> stored byte
  function automatic logic [7:0] bin_to_fld(input logic [6:0] b, input logic bin);
    logic [3:0] tens, ones;
    if (bin) return {1'b0, b};
    tens = 4'(b / 7'd10);
    ones = 4'(b - 7'(tens) * 7'd10);
    return {tens, ones};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

  // {wrapped, next byte}
  function automatic logic [8:0] wrap_inc(input logic [7:0] v, input logic bin,
                                          input logic [6:0] top, input logic [6:0] floor);
    logic [6:0] b;
    b = fld_to_bin(v, bin);
    if (b >= top) return {1'b1, bin_to_fld(floor, bin)};
    return {1'b0, bin_to_fld(b + 7'd1, bin)};
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int unsigned CYC_PER_SEC = 32768,
  parameter int unsigned UIP_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic uip
);
  localparam int CW = (CYC_PER_SEC > 2) ? $clog2(CYC_PER_SEC) : 2;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_SEC - 1);
  localparam logic [CW-1:0] BUSY_FROM = CW'(CYC_PER_SEC - UIP_CYCLES);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);
  assign uip  = (cnt_q >= BUSY_FROM);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    bin_mode,
  input  logic [NFIELD-1:0]       fld_we,
  input  logic [7:0]              wdata,
  output logic [NFIELD-1:0][7:0]  fld_q,
  output logic [NFIELD:0]         carry
);
  localparam logic [NFIELD-1:0][7:0] RST_VAL =
    {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NFIELD-1:0][6:0] FLOOR =
    {7'd0, 7'd1, 7'd1, 7'd0, 7'd0, 7'd0};

  logic [NFIELD-1:0][6:0] lim;
  logic [NFIELD-1:0][8:0] stp;
  logic [6:0] dlen;

  always_comb begin
    dlen = month_len(fld_to_bin(fld_q[4], bin_mode), fld_to_bin(fld_q[5], bin_mode));
    lim  = {7'd99, 7'd12, dlen, 7'd23, 7'd59, 7'd59};
    carry[0] = tick;
    for (int i = 0; i < NFIELD; i++) begin
      stp[i] = wrap_inc(fld_q[i], bin_mode, lim[i], FLOOR[i]);
      carry[i+1] = carry[i] & stp[i][8];
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)        fld_q[g] <= RST_VAL[g];
      else if (fld_we[g]) fld_q[g] <= wdata;
      else if (carry[g])  fld_q[g] <= stp[g][7:0];
    end
  end
endmodule

// File: rtl/rtc_port_clock.sv
module rtc_port_clock import rtc_pkg::*; #(
  parameter logic [7:0]  INDEX_PORT  = 8'h70,
  parameter logic [7:0]  DATA_PORT   = 8'h71,
  parameter int unsigned CYC_PER_SEC = 32768,
  parameter int unsigned UIP_CYCLES  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata
);
  logic [7:0] idx_q;
  logic       data_sel, idx_wr, data_wr;
  logic       tick, uip;
  logic       bin_mode, mode_we;
  logic [7:0] shut_q;
  logic       shut_we;
  logic [NFIELD-1:0]      fld_we;
  logic [NFIELD-1:0][7:0] fld_q;
  logic [NFIELD:0]        carry;
  logic [7:0] rd_val;

  assign data_sel = (io_addr == DATA_PORT);
  assign idx_wr   = io_wr && (io_addr == INDEX_PORT);
  assign data_wr  = io_wr && data_sel;
  assign mode_we  = data_wr && (idx_q == IDX_STB);
  assign shut_we  = data_wr && (idx_q == IDX_SHUT);

  for (genvar g = 0; g < NFIELD; g++) begin : g_we
    assign fld_we[g] = data_wr && (idx_q == FIELD_IDX[g]);
  end

  rtc_prescale #(.CYC_PER_SEC(CYC_PER_SEC), .UIP_CYCLES(UIP_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uip(uip));

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode),
    .fld_we(fld_we), .wdata(io_wdata), .fld_q(fld_q), .carry(carry));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      bin_mode <= 1'b0;
      shut_q   <= '0;
    end else begin
      if (idx_wr)  idx_q    <= io_wdata;
      if (mode_we) bin_mode <= io_wdata[MODE_BIT];
      if (shut_we) shut_q   <= io_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NFIELD; i++)
      if (idx_q == FIELD_IDX[i]) rd_val = fld_q[i];
    case (idx_q)
      IDX_STA:  rd_val = {uip, 7'b0};
      IDX_STB:  rd_val = 8'(bin_mode) << MODE_BIT;
      IDX_SHUT: rd_val = shut_q;
      default:  ;
    endcase
  end

  assign io_rdata = data_sel ? rd_val : 8'h00;
endmodule

// File: rtl/rtc_port_clock_chk.sv
module rtc_port_clock_chk import rtc_pkg::*; (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   uip,
  input logic                   bin_mode,
  input logic                   data_sel,
  input logic                   shut_we,
  input logic [7:0]             idx_q,
  input logic [7:0]             shut_q,
  input logic [7:0]             io_rdata,
  input logic [NFIELD-1:0]      fld_we,
  input logic [NFIELD-1:0][7:0] fld_q,
  input logic [NFIELD:0]        carry
);
  function automatic logic known_idx(input logic [7:0] x);
    logic k;
    k = (x == IDX_STA) || (x == IDX_STB) || (x == IDX_SHUT);
    for (int i = 0; i < NFIELD; i++) k = k || (x == FIELD_IDX[i]);
    return k;
  endfunction

  AST_TICK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> uip);  // R3
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !uip);  // R3
  AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && fld_we == '0) |=> $stable(fld_q));  // R4
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[0] && !fld_we[0] && fld_to_bin(fld_q[0], bin_mode) == 7'd59) |=> fld_q[0] == 8'h00);  // R5
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[2] && !fld_we[2] && fld_to_bin(fld_q[2], bin_mode) == 7'd23) |=> fld_q[2] == 8'h00);  // R5
  AST_DAY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[4] && !fld_we[3]) |=> fld_q[3] == 8'h01);  // R6
  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[4] && !fld_we[4] && fld_to_bin(fld_q[4], bin_mode) == 7'd12) |=> fld_q[4] == 8'h01);  // R7
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[6] && !fld_we[5]) |=> fld_q[5] == 8'h00);  // R7
  AST_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_we |=> $stable(shut_q));  // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_sel && !known_idx(idx_q)) |-> io_rdata == 8'h00);  // R11
endmodule

bind rtc_port_clock rtc_port_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .uip(uip), .bin_mode(bin_mode),
  .data_sel(data_sel), .shut_we(shut_we), .idx_q(idx_q), .shut_q(shut_q),
  .io_rdata(io_rdata), .fld_we(fld_we), .fld_q(fld_q), .carry(carry));

// File: tb/sim_rtc_port_clock.sv
module sim_rtc_port_clock;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 64;
  localparam int BUSY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [7:0] io_addr = 8'h71;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;

  int n_tests = 0;
  int n_fail = 0;

  rtc_port_clock #(.CYC_PER_SEC(CYC), .UIP_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_cnt = 0, m_idx = 0, m_mode = 0, m_shut = 0, ticks = 0;
  int m_fld[6] = '{0, 0, 0, 1, 1, 0};
  int codes[6] = '{0, 2, 4, 7, 8, 9};

  function automatic int dec(int v);
    return m_mode ? v : (v / 16) * 10 + v % 16;
  endfunction
  function automatic int enc(int b);
    return m_mode ? b : (b / 10) * 16 + b % 10;
  endfunction
  function automatic int days(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic int mread();
    if (io_addr != 8'h71) return 0;
    for (int k = 0; k < 6; k++) if (m_idx == codes[k]) return m_fld[k];
    if (m_idx == 10) return (m_cnt >= CYC - BUSY) ? 128 : 0;
    if (m_idx == 11) return m_mode ? 4 : 0;
    if (m_idx == 15) return m_shut;
    return 0;
  endfunction

  always @(posedge clk) begin
    int nf[6];
    int t[6];
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_mode = 0; m_shut = 0;
      m_fld = '{0, 0, 0, 1, 1, 0};
    end else begin
      nf = m_fld;
      if (m_cnt == CYC - 1) begin
        for (int k = 0; k < 6; k++) t[k] = dec(m_fld[k]);
        t[0]++;
        if (t[0] > 59) begin
          t[0] = 0; t[1]++;
          if (t[1] > 59) begin
            t[1] = 0; t[2]++;
            if (t[2] > 23) begin
              t[2] = 0;
              if (t[3] + 1 > days(t[4], t[5])) begin
                t[3] = 1; t[4]++;
                if (t[4] > 12) begin
                  t[4] = 1; t[5]++;
                  if (t[5] > 99) t[5] = 0;
                end
              end else t[3]++;
            end
          end
        end
        for (int k = 0; k < 6; k++) nf[k] = enc(t[k]);
        m_cnt = 0;
        ticks++;
      end else m_cnt++;
      if (io_wr && io_addr == 8'h71) begin
        for (int k = 0; k < 6; k++) if (m_idx == codes[k]) nf[k] = int'(io_wdata);
        if (m_idx == 11) m_mode = (int'(io_wdata) >> 2) & 1;
        if (m_idx == 15) m_shut = int'(io_wdata);
      end
      if (io_wr && io_addr == 8'h70) m_idx = int'(io_wdata);
      m_fld = nf;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R4 (and all others): port output against the model on every clock
  always @(negedge clk) if (rst_n) chk("R4 model", int'(io_rdata), mread());

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0; io_addr = 8'h71;
  endtask
  task automatic setr(input logic [7:0] idx, input logic [7:0] v);
    wr(8'h70, idx); wr(8'h71, v);
  endtask
  task automatic rd(input logic [7:0] idx, output int v);
    wr(8'h70, idx);
    @(negedge clk); v = int'(io_rdata);
  endtask
  task automatic expect_reg(input string req, input logic [7:0] idx, input int exp);
    int v;
    rd(idx, v);
    chk(req, v, exp);
  endtask
  task automatic wait_ticks(input int n);
    int target = ticks + n;
    while (ticks < target) @(negedge clk);
  endtask
  task automatic load(input int y, input int mo, input int d, input int h, input int mi, input int s);
    wait_ticks(1);
    setr(8'h09, 8'(y)); setr(8'h08, 8'(mo)); setr(8'h07, 8'(d));
    setr(8'h04, 8'(h)); setr(8'h02, 8'(mi)); setr(8'h00, 8'(s));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int busy_n, v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state
    expect_reg("R2 sec", 8'h00, 0);
    expect_reg("R2 min", 8'h02, 0);
    expect_reg("R2 hour", 8'h04, 0);
    expect_reg("R2 day", 8'h07, 1);
    expect_reg("R2 month", 8'h08, 1);
    expect_reg("R2 year", 8'h09, 0);
    expect_reg("R2 ctrl", 8'h0B, 0);
    expect_reg("R2 spare", 8'h0F, 0);

    // R1 R3 one advance in BCD; R5 R6 rollover into March of a non-leap year
    load(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
    wait_ticks(1);
    expect_reg("R1 R3 sec 58->59", 8'h00, 8'h59);
    wait_ticks(1);
    expect_reg("R5 sec wrap", 8'h00, 8'h00);
    expect_reg("R5 min wrap", 8'h02, 8'h00);
    expect_reg("R5 hour wrap", 8'h04, 8'h00);
    expect_reg("R6 day to 1", 8'h07, 8'h01);
    expect_reg("R6 month to 3", 8'h08, 8'h03);

    // R6 leap February
    load(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wait_ticks(1);
    expect_reg("R6 leap day 29", 8'h07, 8'h29);
    expect_reg("R6 leap month", 8'h08, 8'h02);
    load(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    wait_ticks(1);
    expect_reg("R6 leap end", 8'h07, 8'h01);
    expect_reg("R6 leap to March", 8'h08, 8'h03);

    // R6 thirty-day month
    load(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    wait_ticks(1);
    expect_reg("R6 april end", 8'h08, 8'h05);

    // R7 year wrap
    load(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    wait_ticks(1);
    expect_reg("R7 year wrap", 8'h09, 8'h00);
    expect_reg("R7 month wrap", 8'h08, 8'h01);
    expect_reg("R7 day", 8'h07, 8'h01);

    // R8 R9 binary mode
    wait_ticks(1);
    setr(8'h00, 8'h09);
    setr(8'h0B, 8'h04);
    expect_reg("R9 no conversion", 8'h00, 8'h09);
    expect_reg("R8 ctrl readback", 8'h0B, 8'h04);
    wait_ticks(1);
    expect_reg("R8 binary 9->10", 8'h00, 8'h0A);
    wait_ticks(1);
    setr(8'h00, 8'd59); setr(8'h02, 8'd5);
    wait_ticks(1);
    expect_reg("R8 R5 binary sec wrap", 8'h00, 8'h00);
    expect_reg("R8 R5 binary min carry", 8'h02, 8'h06);
    setr(8'h0B, 8'hFB);
    expect_reg("R8 ctrl other bits", 8'h0B, 8'h00);
    expect_reg("R9 min kept", 8'h02, 8'h06);

    // R10 spare byte
    wait_ticks(1);
    setr(8'h0F, 8'hA5);
    expect_reg("R10 spare A5", 8'h0F, 8'hA5);
    setr(8'h0F, 8'h3C);
    expect_reg("R10 spare 3C", 8'h0F, 8'h3C);

    // R11 unused codes and read-only status
    setr(8'h05, 8'h77);
    expect_reg("R11 unused 05", 8'h05, 0);
    expect_reg("R11 unused 01", 8'h01, 0);
    setr(8'h0A, 8'hFF);
    expect_reg("R11 status low bits", 8'h0A, 0);
    expect_reg("R10 spare untouched", 8'h0F, 8'h3C);
    io_addr = 8'h70;
    @(negedge clk);
    chk("R1 selector port reads 0", int'(io_rdata), 0);
    io_addr = 8'h71;

    // R3 busy window length over one full second
    wait_ticks(1);
    rd(8'h0A, v);
    busy_n = 0;
    for (int c = 0; c < CYC; c++) begin
      if (io_rdata[7]) busy_n++;
      @(negedge clk);
    end
    chk("R3 busy cycles", busy_n, BUSY);

    finish_run();
  end
endmodule